// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the program counter of a simple in-order core and works out, for every instruction, the address that execution goes to next. The decode stage hands it a control-flow class (straight-line, conditional branch, jump with link, register-indirect jump with link), a comparison kind, the two register operands and a sign-extended immediate. The unit answers in the same cycle with the next address, a flag saying that the fetch stream must be redirected, and the return address to be written back for linking jumps.

The PC register changes only on a clock edge where the instruction-valid strobe is high. It then loads the computed next address. Branch and direct-jump offsets are in units of two bytes. The register-indirect jump adds the immediate to the first operand in bytes and forces the lowest bit of the result to zero. All address arithmetic wraps modulo 2^32.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is held at the parameter `RESET_VEC` (default 0x0000_1000).
- R2: On a rising clock edge with `instr_valid` high, `pc_q` takes the value `next_pc` had before that edge. With `instr_valid` low, `pc_q` keeps its value.
- R3: Class code 0 (straight-line) gives `next_pc = pc_q + 4`.
- R4: Class code 1 (conditional) tests the operands using `cond_kind`. Code 000 is taken when `rs1_val == rs2_val`. Code 001 is taken when they differ. Codes 010 and 011 are never taken.
- R5: Condition codes 100 (less-than) and 101 (greater-or-equal) compare `rs1_val` against `rs2_val` as signed two's-complement values.
- R6: Condition codes 110 (less-than) and 111 (greater-or-equal) compare the operands as unsigned values.
- R7: A taken conditional gives `next_pc = pc_q + 2*imm_val`, which can point backward for a negative immediate. A branch that is not taken gives `pc_q + 4`.
- R8: Class code 2 (direct jump with link) gives `next_pc = pc_q + 2*imm_val`.
- R9: Class code 3 (register-indirect jump with link) gives `next_pc = (rs1_val + imm_val)` with bit 0 cleared.
- R10: `link_val` is always `pc_q + 4`. `link_we` is high only when `instr_valid` is high, the class is 2 or 3, and `rd_idx` is not 0. A destination of register 0 produces no write.
- R11: `redirect` is high exactly when `instr_valid` is high and `next_pc` differs from `pc_q + 4`. This includes a taken branch whose target happens to equal `pc_q + 4`, which raises no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| ctrl_class | input | 2 | Control-flow class: 0 straight, 1 conditional, 2 direct jump, 3 indirect jump |
| cond_kind | input | 3 | Comparison kind for conditional branches |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| imm_val | input | 32 | Sign-extended immediate |
| rd_idx | input | 5 | Destination register index |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address of the following instruction |
| redirect | output | 1 | Next address is not the sequential one |
| link_val | output | 32 | Return address for linking jumps |
| link_we | output | 1 | Link value is to be written to `rd_idx` |

## Verification
The assertions assume that `instr_valid`, `ctrl_class`, `rd_idx` and the operands are stable between clock edges. They also assume that `pc_q + 4` is the reference for sequential flow. The bench drives every input on the falling edge. It samples the combinational outputs one time unit later and samples `pc_q` one time unit after the rising edge, so inputs never change near the edge that consumes them. The bench keeps `instr_valid` low during reset and between scenarios. This lets the hold rule and the gating of `redirect` and `link_we` be seen at the ports.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_JAL    = 2'd2,
        FLOW_JALR   = 2'd3
    } flow_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'b000,
        CMP_NE  = 3'b001,
        CMP_LT  = 3'b100,
        CMP_GE  = 3'b101,
        CMP_LTU = 3'b110,
        CMP_GEU = 3'b111
    } cmp_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
    parameter int XLEN = 32
) (
    input  logic [2:0]      cmp_kind,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            take
);
    import nextpc_pkg::*;

    logic same;
    logic below_s;
    logic below_u;

    assign same    = (op_a == op_b);
    assign below_s = ($signed(op_a) < $signed(op_b));
    assign below_u = (op_a < op_b);

    always_comb begin
        case (cmp_kind)
            CMP_EQ:  take = same;
            CMP_NE:  take = !same;
            CMP_LT:  take = below_s;
            CMP_GE:  take = !below_s;
            CMP_LTU: take = below_u;
            CMP_GEU: take = !below_u;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN      = 32,
    parameter int REL_SHIFT = 1
) (
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] rel_tgt,
    output logic [XLEN-1:0] abs_tgt
);
    localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-1){1'b1}}, 1'b0};

    logic [XLEN-1:0] imm_scaled;
    logic [XLEN-1:0] abs_raw;

    assign imm_scaled = imm << REL_SHIFT;
    assign rel_tgt    = pc_cur + imm_scaled;
    assign abs_raw    = base + imm;
    assign abs_tgt    = abs_raw & ALIGN_MASK;
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] d,
    output logic [XLEN-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VEC;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
    parameter int          XLEN      = 32,
    parameter int          REG_BITS  = 5,
    parameter int          STEP      = 4,
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [1:0]          ctrl_class,
    input  logic [2:0]          cond_kind,
    input  logic [XLEN-1:0]     rs1_val,
    input  logic [XLEN-1:0]     rs2_val,
    input  logic [XLEN-1:0]     imm_val,
    input  logic [REG_BITS-1:0] rd_idx,
    output logic [XLEN-1:0]     pc_q,
    output logic [XLEN-1:0]     next_pc,
    output logic                redirect,
    output logic [XLEN-1:0]     link_val,
    output logic                link_we
);
    import nextpc_pkg::*;

    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);
    localparam logic [XLEN-1:0] RST_V  = XLEN'(RESET_VEC);

    flow_e           flow;
    logic            br_take;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;
    logic            links;

    assign flow   = flow_e'(ctrl_class);
    assign pc_seq = pc_q + STEP_V;

    npc_cond #(.XLEN(XLEN)) u_cond (
        .cmp_kind (cond_kind),
        .op_a     (rs1_val),
        .op_b     (rs2_val),
        .take     (br_take)
    );

    npc_target #(.XLEN(XLEN), .REL_SHIFT(1)) u_tgt (
        .pc_cur  (pc_q),
        .base    (rs1_val),
        .imm     (imm_val),
        .rel_tgt (rel_tgt),
        .abs_tgt (abs_tgt)
    );

    npc_pcreg #(.XLEN(XLEN), .RESET_VEC(RST_V)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (instr_valid),
        .d     (next_pc),
        .q     (pc_q)
    );

    always_comb begin
        links = 1'b0;
        unique case (flow)
            FLOW_SEQ: begin
                next_pc = pc_seq;
            end
            FLOW_BRANCH: begin
                next_pc = br_take ? rel_tgt : pc_seq;
            end
            FLOW_JAL: begin
                next_pc = rel_tgt;
                links   = 1'b1;
            end
            FLOW_JALR: begin
                next_pc = abs_tgt;
                links   = 1'b1;
            end
            default: begin
                next_pc = pc_seq;
            end
        endcase
    end

    assign redirect = instr_valid && (next_pc != pc_seq);
    assign link_val = pc_seq;
    assign link_we  = instr_valid && links && (rd_idx != '0);
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
    parameter int          XLEN      = 32,
    parameter int          REG_BITS  = 5,
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [1:0]          ctrl_class,
    input  logic [REG_BITS-1:0] rd_idx,
    input  logic [XLEN-1:0]     pc_q,
    input  logic [XLEN-1:0]     next_pc,
    input  logic                redirect,
    input  logic [XLEN-1:0]     link_val,
    input  logic                link_we
);
    localparam logic [XLEN-1:0] FOUR = XLEN'(4);

    // R1
    a_r1_reset_vec: assert property (@(posedge clk)
        !rst_n |=> pc_q == XLEN'(RESET_VEC));

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(pc_q));

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> pc_q == $past(next_pc));

    // R3
    a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && ctrl_class == 2'd0) |-> (next_pc == pc_q + FOUR && !redirect));

    // R9
    a_r9_even_target: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && ctrl_class == 2'd3) |-> next_pc[0] == 1'b0);

    // R10
    a_r10_link_gate: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (instr_valid && ctrl_class[1] && rd_idx != '0 && link_val == pc_q + FOUR));

    // R11
    a_r11_redirect_valid: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (instr_valid && next_pc != pc_q + FOUR));
endmodule

bind nextpc_unit nextpc_unit_chk #(
    .XLEN(XLEN), .REG_BITS(REG_BITS), .RESET_VEC(RESET_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .ctrl_class  (ctrl_class),
    .rd_idx      (rd_idx),
    .pc_q        (pc_q),
    .next_pc     (next_pc),
    .redirect    (redirect),
    .link_val    (link_val),
    .link_we     (link_we)
);

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;
    localparam int          CLK_P = 10;
    localparam logic [31:0] RV    = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [1:0]  ctrl_class = '0;
    logic [2:0]  cond_kind = '0;
    logic [31:0] rs1_val = '0, rs2_val = '0, imm_val = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] pc_q, next_pc, link_val;
    logic        redirect, link_we;

    int checks = 0;
    int errors = 0;
    logic [31:0] mpc;

    always #(CLK_P/2) clk = ~clk;

    nextpc_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .ctrl_class(ctrl_class), .cond_kind(cond_kind),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm_val(imm_val),
        .rd_idx(rd_idx), .pc_q(pc_q), .next_pc(next_pc),
        .redirect(redirect), .link_val(link_val), .link_we(link_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic taken(input logic [2:0] k, input logic [31:0] a, input logic [31:0] b);
        case (k)
            3'b000: return a == b;
            3'b001: return a != b;
            3'b100: return $signed(a) < $signed(b);
            3'b101: return $signed(a) >= $signed(b);
            3'b110: return a < b;
            3'b111: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    // One instruction: drive at falling edge, check outputs, then check the PC after the edge.
    task automatic run_instr(input string req, input logic [1:0] cls, input logic [2:0] k,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] imm, input logic [4:0] rd);
        logic [31:0] exp_n, seq;
        @(negedge clk);
        instr_valid = 1'b1; ctrl_class = cls; cond_kind = k;
        rs1_val = a; rs2_val = b; imm_val = imm; rd_idx = rd;
        seq = mpc + 32'd4;
        case (cls)
            2'd0: exp_n = seq;
            2'd1: exp_n = taken(k, a, b) ? mpc + (imm << 1) : seq;
            2'd2: exp_n = mpc + (imm << 1);
            default: exp_n = (a + imm) & 32'hFFFF_FFFE;
        endcase
        #1;
        chk({req, " next_pc"}, next_pc, exp_n);
        chk("R11 redirect", {31'd0, redirect}, {31'd0, exp_n != seq});
        chk("R10 link_val", link_val, seq);
        chk("R10 link_we", {31'd0, link_we}, {31'd0, (cls[1] && rd != 5'd0)});
        @(posedge clk); #1;
        mpc = exp_n;
        chk("R2 pc load", pc_q, mpc);
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R1 reset vector", pc_q, RV);
        @(negedge clk) rst_n = 1'b1;
        mpc = RV;
        @(posedge clk); #1 chk("R1 after release", pc_q, RV);
    endtask

    task automatic t_hold;
        @(negedge clk);
        instr_valid = 1'b0; ctrl_class = 2'd2; imm_val = 32'h40; rd_idx = 5'd1;
        #1;
        chk("R11 no redirect idle", {31'd0, redirect}, 32'd0);
        chk("R10 no link idle", {31'd0, link_we}, 32'd0);
        repeat (2) @(posedge clk);
        #1 chk("R2 hold", pc_q, mpc);
    endtask

    task automatic t_seq;
        run_instr("R3 seq", 2'd0, 3'd0, 32'd5, 32'd9, 32'h100, 5'd3);
        run_instr("R3 seq again", 2'd0, 3'd1, 32'd0, 32'd0, 32'd0, 5'd0);
    endtask

    task automatic t_eq_ne;
        run_instr("R4 eq taken", 2'd1, 3'b000, 32'd7, 32'd7, 32'h10, 5'd0);
        run_instr("R4 eq not taken", 2'd1, 3'b000, 32'd7, 32'd8, 32'h10, 5'd0);
        run_instr("R4 ne taken", 2'd1, 3'b001, 32'd1, 32'd2, 32'h20, 5'd0);
        run_instr("R4 ne not taken", 2'd1, 3'b001, 32'd3, 32'd3, 32'h20, 5'd0);
        run_instr("R4 unused code", 2'd1, 3'b010, 32'd3, 32'd3, 32'h20, 5'd0);
    endtask

    task automatic t_signed;
        run_instr("R5 lt neg<pos", 2'd1, 3'b100, 32'hFFFF_FFFF, 32'd1, 32'h8, 5'd0);
        run_instr("R5 ge neg<pos", 2'd1, 3'b101, 32'hFFFF_FFFF, 32'd1, 32'h8, 5'd0);
        run_instr("R5 ge equal", 2'd1, 3'b101, 32'h8000_0000, 32'h8000_0000, 32'h8, 5'd0);
    endtask

    task automatic t_unsigned;
        run_instr("R6 ltu big", 2'd1, 3'b110, 32'hFFFF_FFFF, 32'd1, 32'h8, 5'd0);
        run_instr("R6 geu big", 2'd1, 3'b111, 32'hFFFF_FFFF, 32'd1, 32'h8, 5'd0);
    endtask

    task automatic t_backward;
        run_instr("R7 backward", 2'd1, 3'b000, 32'd0, 32'd0, 32'hFFFF_FFF0, 5'd0);
        run_instr("R11 target equals pc+4", 2'd1, 3'b000, 32'd0, 32'd0, 32'd2, 5'd0);
    endtask

    task automatic t_jumps;
        run_instr("R8 jal link", 2'd2, 3'd0, 32'd0, 32'd0, 32'h200, 5'd1);
        run_instr("R10 jal rd0", 2'd2, 3'd0, 32'd0, 32'd0, 32'hFFFF_FF00, 5'd0);
        run_instr("R9 jalr odd", 2'd3, 3'd0, 32'h0000_3001, 32'd0, 32'h4, 5'd5);
        run_instr("R9 jalr neg", 2'd3, 3'd0, 32'h0000_2000, 32'd0, 32'hFFFF_FFFF, 5'd0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mpc = RV;
        t_reset();
        t_hold();
        t_seq();
        t_eq_ne();
        t_signed();
        t_unsigned();
        t_backward();
        t_jumps();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule